// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the two-wire slave front end of a byte-addressed non-volatile memory with a 17-bit address space (128K bytes). It runs on a system clock, oversamples the bus clock and data lines, and finds START and STOP conditions. It checks the device-select byte, assembles the array address, and serves byte writes, page writes, current-address reads, random reads and sequential reads. A small on-chip register array stands in for the non-volatile array.

Writes are collected in a page buffer and copied into the array only after STOP. While that copy runs, the block models an internal write time and refuses its device-select byte. This lets a host poll for completion by retrying until it gets an acknowledge. A hardware write-protect input blocks every array update. The block never drives SDA high. It only asserts an output-enable that pulls the open-drain line low.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset `sdaOe` is low and the block is idle. A START (SDA falling while SCL is high) opens a transfer at the device-select byte, even in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle.
- R2: A device-select byte is accepted only if its bits 7:4 equal 4'b1010, bit 3 is 0, bit 2 equals the `a1Sel` input and no write is busy. Otherwise SDA stays released during the ninth clock and the block ignores the bus until the next START.
- R3: Every accepted byte is acknowledged by pulling SDA low during the ninth SCL clock. This covers the device-select byte, both address bytes and every write data byte. `sdaOe` changes only while SCL is low.
- R4: A device-select byte with bit 0 = 0 (write) loads its bit 1 into address bit 16. The next two bytes load address bits 15:8 and then bits 7:0. In a device-select byte with bit 0 = 1 (read), bit 1 is ignored.
- R5: Data bytes after the address are placed at the current address. After each byte, address bits 6:0 increment and wrap inside the 128-byte page while bits 16:7 stay fixed. The bytes reach the array only after the STOP. One byte followed by STOP is a byte write.
- R6: While `wpIn` is high, write data bytes are still acknowledged, but they are dropped. The array keeps its contents and no busy period starts, so the next device-select byte is acknowledged at once.
- R7: A STOP that ends a write with at least one kept byte starts a busy period of max(BUSY_CYCLES, 128) clock cycles. During that period the device-select byte is not acknowledged. After it ends, the device-select byte is acknowledged again.
- R8: A device-select byte with bit 0 = 1 returns the byte at the current address counter. The counter always points one past the last byte read or written.
- R9: A device-select write, two address bytes and a repeated START with a read device-select return the byte at the newly loaded address (random read).
- R10: In a read, the full 17-bit address increments after every byte and wraps from 0x1FFFF to 0. The master's acknowledge continues the read. A master non-acknowledge ends it, and SDA is released.
- R11: The stand-in array has 2^MEM_AW bytes. Array address A maps to entry A mod 2^MEM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Resolved bus data level |
| a1Sel | input | 1 | Level compared with bit 2 of the device-select byte |
| wpIn | input | 1 | High blocks every array write |
| sdaOe | output | 1 | High pulls the open-drain SDA line low |

## Verification
The assertions assume the master changes SDA only while SCL is low, except for START and STOP. They also assume each SCL phase lasts longer than the three-cycle synchronizer and edge-detect delay. The bench holds each SCL half-period for ten system clocks and moves SDA halfway through the low phase. During busy time the master only polls with device-select bytes, which the block refuses, so the page buffer cannot change while it is being copied. The device-select sweep covers every pattern of bits 7:2 for both `a1Sel` levels.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int EE_ADDR_W = 17;

  typedef struct packed {
    logic clrBit;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ldA16;
    logic ldAHi;
    logic ldALo;
    logic wrByte;
    logic rdInc;
    logic commit;
  } ee_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKO,
    ST_TX,
    ST_ACKI
  } ee_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } ee_phase_t;
endpackage

// File: rtl/ee_data.sv
module ee_data
  import ee_pkg::*;
#(
  parameter int PAGE_W      = 7,
  parameter int MEM_AW      = 9,
  parameter int BUSY_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wpIn,
  input  ee_strobe_t strobe,
  output logic       sclS,
  output logic       sdaS,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic [3:0] bitCnt,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       busy
);
  localparam int ADDR_W   = EE_ADDR_W;
  localparam int PAGE_N   = 1 << PAGE_W;
  localparam int MEM_N    = 1 << MEM_AW;
  localparam int BUSY_LEN = (BUSY_CYCLES > PAGE_N) ? BUSY_CYCLES : PAGE_N;
  localparam int BUSY_W   = $clog2(BUSY_LEN + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  logic [7:0]        rxSh, txSh;
  logic [ADDR_W-1:0] addrQ, rdAddr, wrAddr;
  logic [7:0]        pageBuf [PAGE_N];
  logic [PAGE_N-1:0] validQ;
  logic              committing;
  logic [PAGE_W-1:0] cIdx;
  logic [BUSY_W-1:0] busyCnt;
  logic [7:0]        mem [MEM_N];
  logic              memWe;

  assign rxByte = rxSh;
  assign txMsb  = txSh[7];
  assign busy   = (busyCnt != '0);
  assign rdAddr = strobe.rdInc ? addrQ + ADDR_W'(1) : addrQ;
  assign wrAddr = {addrQ[ADDR_W-1:PAGE_W], cIdx};
  assign memWe  = committing & validQ[cIdx];

  // bit counter and byte shifters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt <= '0;
      rxSh   <= '0;
      txSh   <= '0;
    end else begin
      if (strobe.rxShift) rxSh <= {rxSh[6:0], sdaS};
      if (strobe.txLoad) txSh <= mem[rdAddr[MEM_AW-1:0]];
      else if (strobe.txShift) txSh <= {txSh[6:0], 1'b0};
      if (strobe.clrBit) bitCnt <= '0;
      else if (strobe.rxShift || strobe.txShift) bitCnt <= bitCnt + 4'd1;
    end
  end

  // address counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
    end else begin
      if (strobe.ldA16) addrQ[ADDR_W-1] <= rxSh[1];
      if (strobe.ldAHi) addrQ[15:8] <= rxSh;
      if (strobe.ldALo) addrQ[7:0] <= rxSh;
      if (strobe.wrByte) addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + PAGE_W'(1);
      if (strobe.rdInc) addrQ <= addrQ + ADDR_W'(1);
    end
  end

  // page buffer data
  always_ff @(posedge clk) begin
    if (strobe.wrByte && !wpIn) pageBuf[addrQ[PAGE_W-1:0]] <= rxSh;
  end

  // commit engine and busy timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ     <= '0;
      committing <= 1'b0;
      cIdx       <= '0;
      busyCnt    <= '0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - BUSY_W'(1);
      if (committing) begin
        validQ[cIdx] <= 1'b0;
        cIdx         <= cIdx + PAGE_W'(1);
        if (cIdx == '1) committing <= 1'b0;
      end else if (strobe.commit && (|validQ)) begin
        committing <= 1'b1;
        cIdx       <= '0;
        busyCnt    <= BUSY_W'(BUSY_LEN);
      end
      if (strobe.wrByte && !wpIn) validQ[addrQ[PAGE_W-1:0]] <= 1'b1;
    end
  end

  // stand-in array
  always_ff @(posedge clk) begin
    if (memWe) mem[wrAddr[MEM_AW-1:0]] <= pageBuf[cIdx];
  end

  p_wp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrByte && wpIn && !committing) |=> $stable(validQ))
    else $error("write-protected byte entered the page buffer");

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrByte |=> (addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W])) &&
                      (addrQ[PAGE_W-1:0] == PAGE_W'($past(addrQ[PAGE_W-1:0]) + PAGE_W'(1))))
    else $error("page address did not wrap inside the page");

  p_seq_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rdInc |=> addrQ == ADDR_W'($past(addrQ) + ADDR_W'(1)))
    else $error("read address did not advance");

  p_mem_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy)
    else $error("array written outside busy period");
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       busy,
  input  logic       a1Sel,
  output ee_strobe_t strobe,
  output logic       sdaOe
);
  ee_state_t stateQ, stateD;
  ee_phase_t phaseQ, phaseD;
  logic      readQ, readD;
  logic      mAckQ, mAckD;
  logic      devHit;

  assign devHit = (rxByte[7:4] == 4'b1010) && !rxByte[3] && (rxByte[2] == a1Sel) && !busy;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    phaseD = phaseQ;
    readD  = readQ;
    mAckD  = mAckQ;
    if (stopDet) begin
      strobe.commit = 1'b1;
      stateD        = ST_IDLE;
    end else if (startDet) begin
      strobe.clrBit = 1'b1;
      stateD        = ST_RX;
      phaseD        = PH_DEV;
      readD         = 1'b0;
    end else begin
      unique case (stateQ)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strobe.rxShift = 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stateD = ST_ACKO;
            unique case (phaseQ)
              PH_DEV: begin
                if (devHit) begin
                  readD = rxByte[0];
                  if (!rxByte[0]) begin
                    strobe.ldA16 = 1'b1;
                    phaseD       = PH_AHI;
                  end
                end else begin
                  stateD = ST_IDLE;
                end
              end
              PH_AHI: begin
                strobe.ldAHi = 1'b1;
                phaseD       = PH_ALO;
              end
              PH_ALO: begin
                strobe.ldALo = 1'b1;
                phaseD       = PH_DATA;
              end
              default: strobe.wrByte = 1'b1;
            endcase
          end
        end
        ST_ACKO: begin
          if (sclFall) begin
            strobe.clrBit = 1'b1;
            if (readQ) begin
              strobe.txLoad = 1'b1;
              stateD        = ST_TX;
            end else begin
              stateD = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) stateD = ST_ACKI;
            else strobe.txShift = 1'b1;
          end
        end
        ST_ACKI: begin
          if (sclRise) mAckD = !sdaS;
          if (sclFall) begin
            strobe.rdInc = 1'b1;
            if (mAckQ) begin
              strobe.txLoad = 1'b1;
              strobe.clrBit = 1'b1;
              stateD        = ST_TX;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_DEV;
      readQ  <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      readQ  <= readD;
      mAckQ  <= mAckD;
    end
  end

  assign sdaOe = (stateQ == ST_ACKO) || (stateQ == ST_TX && !txMsb);

  p_sda_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclS && $past(sclS)) |-> (sdaOe == $past(sdaOe)))
    else $error("SDA drive changed while SCL high");

  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_RX && phaseQ == PH_DEV && sclFall && bitCnt == 4'd8 &&
     busy && !startDet && !stopDet) |=> (stateQ == ST_IDLE))
    else $error("device select accepted while busy");

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stopDet |=> (stateQ == ST_IDLE && !sdaOe))
    else $error("STOP did not return to idle");
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_pkg::*;
#(
  parameter int PAGE_W      = 7,
  parameter int MEM_AW      = 9,
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic a1Sel,
  input  logic wpIn,
  output logic sdaOe
);
  ee_strobe_t strobe;
  logic       sclS, sdaS, sclRise, sclFall, startDet, stopDet, txMsb, busy;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  ee_data #(
    .PAGE_W(PAGE_W),
    .MEM_AW(MEM_AW),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) uData (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .wpIn(wpIn),
    .strobe(strobe), .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );

  ee_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .bitCnt(bitCnt), .rxByte(rxByte), .txMsb(txMsb), .busy(busy),
    .a1Sel(a1Sel), .strobe(strobe), .sdaOe(sdaOe)
  );
endmodule

// File: tb/tb_ee_i2c_slave.sv
`timescale 1ns/1ps
module tb_ee_i2c_slave;
  localparam int H    = 10;
  localparam int MEMN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic masterLow = 1'b0;
  logic a1Sel = 1'b1;
  logic wpIn = 1'b0;
  logic sdaOe;
  logic sdaLine;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  logic [7:0] model [MEMN];

  assign sdaLine = !(masterLow || sdaOe);

  always #10 clk = ~clk;

  ee_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .sclIn(scl), .sdaIn(sdaLine),
    .a1Sel(a1Sel), .wpIn(wpIn), .sdaOe(sdaOe)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    if (!scl) begin
      waitClk(H/2); masterLow = 1'b0; waitClk(H/2); scl = 1'b1; waitClk(H);
    end
    masterLow = 1'b1; waitClk(H); scl = 1'b0;
  endtask

  task automatic busStop();
    waitClk(H/2); masterLow = 1'b1; waitClk(H/2); scl = 1'b1; waitClk(H);
    masterLow = 1'b0; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      waitClk(H/2); masterLow = !b[i]; waitClk(H/2);
      scl = 1'b1; waitClk(H); scl = 1'b0;
    end
    waitClk(H/2); masterLow = 1'b0; waitClk(H/2);
    scl = 1'b1; waitClk(H/2); ack = !sdaLine; waitClk(H/2); scl = 1'b0;
  endtask

  task automatic recvByte(input logic doAck, output logic [7:0] b);
    masterLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(H); scl = 1'b1; waitClk(H/2); b[i] = sdaLine; waitClk(H/2); scl = 1'b0;
    end
    waitClk(H/2); masterLow = doAck; waitClk(H/2);
    scl = 1'b1; waitClk(H); scl = 1'b0;
    waitClk(H/2); masterLow = 1'b0;
  endtask

  function automatic logic [7:0] devW(input logic [16:0] a);
    return {4'hA, 1'b0, a1Sel, a[16], 1'b0};
  endfunction

  task automatic setAddr(input logic [16:0] a, input string tag);
    logic ack;
    busStart();
    sendByte(devW(a), ack);     chk({tag, " R3 dev ack"}, ack, 1);
    sendByte(a[15:8], ack);     chk({tag, " R3 hi ack"}, ack, 1);
    sendByte(a[7:0], ack);      chk({tag, " R3 lo ack"}, ack, 1);
  endtask

  task automatic pageWrite(input logic [16:0] a, input int n, input logic [7:0] seed);
    logic ack;
    logic [7:0] d;
    logic [6:0] lo;
    logic [16:0] ea;
    setAddr(a, "R5 write");
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 37);
      sendByte(d, ack);
      chk("R3 data ack", ack, 1);
      lo = a[6:0] + 7'(i);
      ea = {a[16:7], lo};
      if (!wpIn) model[ea % MEMN] = d;
    end
    busStop();
  endtask

  task automatic poll(output logic ack);
    busStart();
    sendByte(devW(17'h0), ack);
    busStop();
  endtask

  task automatic waitReady(output int tries);
    logic ack;
    tries = 0;
    ack = 1'b0;
    while (!ack && tries < 12) begin
      poll(ack);
      tries++;
      waitClk(H);
    end
    chk("R7 ready after busy", ack, 1);
  endtask

  task automatic randomRead(input logic [16:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    logic [16:0] ra;
    setAddr(a, tag);
    busStart();
    sendByte({4'hA, 1'b0, a1Sel, 1'b0, 1'b1}, ack);
    chk({tag, " R9 read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      ra = a + 17'(i);
      chk({tag, " R9/R10/R11 data"}, b, model[ra % MEMN]);
    end
    chk({tag, " R10 released after nack"}, sdaOe, 0);
    busStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int tries;
    waitClk(5);
    chk("R1 reset sdaOe", sdaOe, 0);
    rst_n = 1'b1;
    waitClk(5);
    chk("R1 idle after reset", sdaOe, 0);

    // R2 sweep of device-select bits 7:2 for both a1Sel levels
    for (int s = 0; s < 2; s++) begin
      a1Sel = s[0];
      for (int v = 0; v < 64; v++) begin
        logic [7:0] dv;
        logic exp;
        dv  = {v[5:0], 2'b00};
        exp = (dv[7:4] == 4'hA) && !dv[3] && (dv[2] == a1Sel);
        busStart();
        sendByte(dv, ack);
        busStop();
        chk("R2 device select match", ack, exp);
        waitClk(H);
      end
    end
    a1Sel = 1'b1;

    // R5 page write crossing the page end, then R7 busy
    pageWrite(17'h0007E, 4, 8'h21);
    poll(ack);
    chk("R7 nack while busy", ack, 0);
    waitReady(tries);
    chk("R7 polled more than once", tries > 1, 1);

    // R4 bit 16 from device select, R5 byte write
    pageWrite(17'h1FFFF, 1, 8'h5A);
    waitReady(tries);
    pageWrite(17'h00123, 1, 8'hC3);
    waitReady(tries);

    // R9 random reads, R5 wrap contents
    randomRead(17'h0007E, 2, "page end");
    randomRead(17'h00000, 2, "page start");
    randomRead(17'h00123, 1, "byte");

    // R10 wrap from top address to 0, R11 aliasing
    randomRead(17'h1FFFF, 2, "top wrap");

    // R8 current address read, R4 read-mode bit 1 ignored
    busStart();
    sendByte({4'hA, 1'b0, a1Sel, 1'b1, 1'b1}, ack);
    chk("R8 current read dev ack", ack, 1);
    recvByte(1'b0, b);
    chk("R8 R4 current address data", b, model[1]);
    busStop();

    // R1 repeated START mid-write restarts at device select
    busStart();
    sendByte(devW(17'h0), ack);
    busStart();
    sendByte(8'h13, ack);
    chk("R1 restart reparses dev byte", ack, 0);
    busStop();
    waitClk(H);

    // R6 write protect
    wpIn = 1'b1;
    pageWrite(17'h00123, 1, 8'h11);
    poll(ack);
    chk("R6 no busy under protect", ack, 1);
    wpIn = 1'b0;
    randomRead(17'h00123, 1, "R6 unchanged");

    summary();
    $finish;
  end
endmodule